// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block keeps the books for a shared packet memory that is carved into 256-byte pages. Software, or a sequencer standing in for it, drives a small command port: it asks for a run of pages, and the block answers later with a packet number (or a failure flag) and raises an allocation interrupt. The allocator finds space with a first-fit search over a page bitmap. It tests one candidate start page per clock, so the time to an answer depends on how fragmented the pool is.

Besides allocation, the block holds three queues of 7-bit packet numbers. The transmit queue is filled by the enqueue command and drained by the MAC. The transmit-done queue is filled by the MAC when a frame has gone out, and that also raises a transmit interrupt. The receive queue is filled by the MAC with received packets; its head is freed and popped by the release command. A free command hands a packet's pages back to the pool, and a reset command clears the whole pool and every queue. The MAC, the data path and the memory array itself are not part of this block.

Top module: `pbuf_alloc`

## Requirements
- R1: After rst_n, every page and packet number is free, all three queues are empty (txq_valid=0, txd_empty=1, rx_empty=1), both interrupt bits are 0 and alloc_result reads 8'h80.
- R2: An allocate command (cmd_op=1, page count on cmd_count) that succeeds sets alloc_result to {1'b0, n}, where n is the lowest free packet number, and sets irq_alloc one or more cycles after the command. alloc_result changes only when irq_alloc is set in the same cycle, or after a reset command.
- R3: An allocate command with cmd_count of 0 or greater than 7 completes as a failure: alloc_result=8'h80 and irq_alloc set.
- R4: Pages are taken as one contiguous run at the lowest start page whose run is entirely free. If no such run exists, or no packet number is free, the allocation fails with alloc_result=8'h80.
- R5: Writing 1 to irq_ack[0] clears irq_alloc and writing 1 to irq_ack[1] clears irq_tx. A 0 leaves a bit unchanged, and a new event in the same cycle as its acknowledge leaves the bit set.
- R6: An allocate command issued while a search is still running is ignored.
- R7: The enqueue command (cmd_op=3) pushes sel_pkt onto the transmit queue, whose head is shown on txq_pkt with txq_valid; txq_take pops it. A sel_pkt that is unallocated or out of range is ignored.
- R8: A pulse on tx_done_valid pushes tx_done_pkt onto the transmit-done queue (head on txd_pkt, txd_empty low, popped by txd_pop) and sets irq_tx.
- R9: The free command (cmd_op=4) returns the pages of packet sel_pkt to the pool and makes its number free again. It leaves every queue unchanged and has no effect on a packet that is not allocated.
- R10: rx_in_valid pushes rx_in_pkt onto the receive queue (head on rx_pkt, rx_empty). The release command (cmd_op=5) frees the head packet's pages and pops it. On an empty queue, release has no effect.
- R11: The reset command (cmd_op=2) frees all pages and packet numbers, empties all queues, clears both interrupt bits, sets alloc_result to 8'h80 and aborts a running search.
- R12: Each queue is first-in first-out with a depth of SLOTS entries. A push into a full queue is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 1 allocate, 2 reset, 3 enqueue, 4 free, 5 release receive head |
| cmd_count | input | 4 | Page count for allocate |
| sel_pkt | input | 7 | Selected packet number for enqueue and free |
| irq_ack | input | 2 | Write-one-to-clear: bit 0 allocation, bit 1 transmit |
| alloc_result | output | 8 | Bit 7 failure, bits 6:0 granted packet number |
| irq_alloc | output | 1 | Allocation complete interrupt bit |
| irq_tx | output | 1 | Transmit complete interrupt bit |
| txq_valid | output | 1 | Transmit queue holds a packet |
| txq_pkt | output | 7 | Transmit queue head |
| txq_take | input | 1 | MAC pops the transmit queue |
| tx_done_valid | input | 1 | MAC reports a finished transmit |
| tx_done_pkt | input | 7 | Packet number of the finished transmit |
| txd_empty | output | 1 | Transmit-done queue empty |
| txd_pkt | output | 7 | Transmit-done queue head |
| txd_pop | input | 1 | Pop the transmit-done queue |
| rx_in_valid | input | 1 | MAC pushes a received packet |
| rx_in_pkt | input | 7 | Received packet number |
| rx_empty | output | 1 | Receive queue empty |
| rx_pkt | output | 7 | Receive queue head |

## Verification
The bench builds the block with PAGES=16 and SLOTS=4. With these values, four one-page requests use up every packet number while most pages are still free, which isolates the packet-number failure from the page failure. Two 7-page runs leave a 2-page tail that a 3-page request cannot fit. Four 4-page packets with alternate ones freed leave eight free pages that are not contiguous, so first-fit placement and its failure both become visible at the result port. A queue depth of four also lets random traffic overfill each queue.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
    localparam int PKT_W   = 7;
    localparam int CNT_W   = 4;
    localparam int MAX_RUN = 7;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_ALLOC = 3'd1,
        OP_RESET = 3'd2,
        OP_ENQ   = 3'd3,
        OP_FREE  = 3'd4,
        OP_RXREL = 3'd5
    } op_e;

    localparam logic [7:0] RES_FAIL = 8'h80;
endpackage

// File: rtl/pbuf_fifo.sv
module pbuf_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         empty,
    output logic [W-1:0] head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_t;

    fifo_t s_d, s_q;
    logic  do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && (s_q.cnt != '0);
        do_push = push && ((s_q.cnt != FULLC) || do_pop);
        if (clr) begin
            s_d.rd  = '0;
            s_d.wr  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wr] = push_data;
                s_d.wr = (s_q.wr == LAST) ? '0 : s_q.wr + 1'b1;
            end
            if (do_pop) begin
                s_d.rd = (s_q.rd == LAST) ? '0 : s_q.rd + 1'b1;
            end
            if (do_push && !do_pop) begin
                s_d.cnt = s_q.cnt + 1'b1;
            end else if (do_pop && !do_push) begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign empty = (s_q.cnt == '0);
    assign head  = s_q.mem[s_q.rd];
endmodule

// File: rtl/pbuf_window.sv
module pbuf_window #(
    parameter int PAGES = 16,
    parameter int BW    = 5,
    parameter int NW    = 4
) (
    input  logic [BW-1:0]    base,
    input  logic [NW-1:0]    len,
    output logic [PAGES-1:0] mask
);
    localparam int SW = ((BW > NW) ? BW : NW) + 1;

    logic [SW-1:0] stop;
    assign stop = SW'(base) + SW'(len);

    for (genvar i = 0; i < PAGES; i++) begin : g_pg
        assign mask[i] = (SW'(i) >= SW'(base)) && (SW'(i) < stop);
    end
endmodule

// File: rtl/pbuf_slotpick.sv
module pbuf_slotpick #(
    parameter int SLOTS = 8,
    parameter int IW    = 3
) (
    input  logic [SLOTS-1:0] used,
    output logic             any_free,
    output logic [IW-1:0]    idx
);
    always_comb begin
        any_free = 1'b0;
        idx      = '0;
        for (int k = SLOTS - 1; k >= 0; k--) begin
            if (!used[k]) begin
                any_free = 1'b1;
                idx      = IW'(k);
            end
        end
    end
endmodule

// File: rtl/pbuf_alloc.sv
module pbuf_alloc
    import pbuf_pkg::*;
#(
    parameter int PAGES = 16,
    parameter int SLOTS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [CNT_W-1:0] cmd_count,
    input  logic [PKT_W-1:0] sel_pkt,
    input  logic [1:0]       irq_ack,
    output logic [7:0]       alloc_result,
    output logic             irq_alloc,
    output logic             irq_tx,
    output logic             txq_valid,
    output logic [PKT_W-1:0] txq_pkt,
    input  logic             txq_take,
    input  logic             tx_done_valid,
    input  logic [PKT_W-1:0] tx_done_pkt,
    output logic             txd_empty,
    output logic [PKT_W-1:0] txd_pkt,
    input  logic             txd_pop,
    input  logic             rx_in_valid,
    input  logic [PKT_W-1:0] rx_in_pkt,
    output logic             rx_empty,
    output logic [PKT_W-1:0] rx_pkt
);
    localparam int IW    = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int PTR_W = $clog2(PAGES + 1);
    localparam int SW    = ((PTR_W > CNT_W) ? PTR_W : CNT_W) + 1;
    localparam logic [PKT_W-1:0] SLOT_LIM = PKT_W'(SLOTS);

    typedef struct packed {
        logic [PAGES-1:0]                 pg_used;
        logic [SLOTS-1:0]                 sl_used;
        logic [SLOTS-1:0][PTR_W-1:0]      sl_base;
        logic [SLOTS-1:0][CNT_W-1:0]      sl_len;
        logic                             busy;
        logic [PTR_W-1:0]                 ptr;
        logic [CNT_W-1:0]                 need;
        logic [7:0]                       result;
        logic                             irq_a;
        logic                             irq_t;
    } st_t;

    st_t s_d, s_q;

    // command decode
    op_e  op;
    logic is_alloc, is_reset, is_enq, is_free, is_rel;
    assign op       = op_e'(cmd_op);
    assign is_alloc = cmd_valid && (op == OP_ALLOC);
    assign is_reset = cmd_valid && (op == OP_RESET);
    assign is_enq   = cmd_valid && (op == OP_ENQ);
    assign is_free  = cmd_valid && (op == OP_FREE);
    assign is_rel   = cmd_valid && (op == OP_RXREL);

    // selected and receive-head packet lookups
    logic          sel_rng, rx_rng, enq_ok, tgt_ok;
    logic [IW-1:0] sel_idx, rx_idx, tgt_idx;
    assign sel_rng = (sel_pkt < SLOT_LIM);
    assign sel_idx = sel_pkt[IW-1:0];
    assign rx_rng  = (rx_pkt < SLOT_LIM);
    assign rx_idx  = rx_pkt[IW-1:0];
    assign enq_ok  = is_enq && sel_rng && s_q.sl_used[sel_idx];
    assign tgt_idx = is_rel ? rx_idx : sel_idx;
    assign tgt_ok  = is_rel ? (!rx_empty && rx_rng && s_q.sl_used[rx_idx])
                            : (is_free && sel_rng && s_q.sl_used[sel_idx]);

    // first-fit scan of one candidate start page per cycle
    logic [PAGES-1:0] scan_mask, rel_mask;
    logic [SW-1:0]    scan_stop;
    logic             scan_over, scan_clash, bad_need;
    logic             any_free;
    logic [IW-1:0]    free_idx;

    pbuf_window #(.PAGES(PAGES), .BW(PTR_W), .NW(CNT_W)) u_scan_win (
        .base (s_q.ptr),
        .len  (s_q.need),
        .mask (scan_mask)
    );

    pbuf_window #(.PAGES(PAGES), .BW(PTR_W), .NW(CNT_W)) u_rel_win (
        .base (s_q.sl_base[tgt_idx]),
        .len  (s_q.sl_len[tgt_idx]),
        .mask (rel_mask)
    );

    pbuf_slotpick #(.SLOTS(SLOTS), .IW(IW)) u_pick (
        .used     (s_q.sl_used),
        .any_free (any_free),
        .idx      (free_idx)
    );

    assign scan_stop  = SW'(s_q.ptr) + SW'(s_q.need);
    assign scan_over  = (scan_stop > SW'(PAGES));
    assign scan_clash = |(scan_mask & s_q.pg_used);
    assign bad_need   = (s_q.need == '0) || (s_q.need > CNT_W'(MAX_RUN));

    always_comb begin
        s_d       = s_q;
        s_d.irq_a = s_q.irq_a & ~irq_ack[0];
        s_d.irq_t = s_q.irq_t & ~irq_ack[1];
        if (tx_done_valid) begin
            s_d.irq_t = 1'b1;
        end

        if (s_q.busy) begin
            if (bad_need || !any_free || scan_over) begin
                s_d.busy   = 1'b0;
                s_d.result = RES_FAIL;
                s_d.irq_a  = 1'b1;
            end else if (!scan_clash) begin
                s_d.busy              = 1'b0;
                s_d.result            = {1'b0, PKT_W'(free_idx)};
                s_d.irq_a             = 1'b1;
                s_d.pg_used           = s_q.pg_used | scan_mask;
                s_d.sl_used[free_idx] = 1'b1;
                s_d.sl_base[free_idx] = s_q.ptr;
                s_d.sl_len[free_idx]  = s_q.need;
            end else begin
                s_d.ptr = s_q.ptr + 1'b1;
            end
        end else if (is_alloc) begin
            s_d.busy = 1'b1;
            s_d.ptr  = '0;
            s_d.need = cmd_count;
        end

        if (tgt_ok) begin
            s_d.pg_used          = s_d.pg_used & ~rel_mask;
            s_d.sl_used[tgt_idx] = 1'b0;
        end

        if (is_reset) begin
            s_d.pg_used = '0;
            s_d.sl_used = '0;
            s_d.busy    = 1'b0;
            s_d.result  = RES_FAIL;
            s_d.irq_a   = 1'b0;
            s_d.irq_t   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.result <= RES_FAIL;
        end else begin
            s_q <= s_d;
        end
    end

    logic txq_empty;

    pbuf_fifo #(.DEPTH(SLOTS), .W(PKT_W)) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (is_reset),
        .push      (enq_ok),
        .push_data (sel_pkt),
        .pop       (txq_take),
        .empty     (txq_empty),
        .head      (txq_pkt)
    );

    pbuf_fifo #(.DEPTH(SLOTS), .W(PKT_W)) u_txd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (is_reset),
        .push      (tx_done_valid),
        .push_data (tx_done_pkt),
        .pop       (txd_pop),
        .empty     (txd_empty),
        .head      (txd_pkt)
    );

    pbuf_fifo #(.DEPTH(SLOTS), .W(PKT_W)) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (is_reset),
        .push      (rx_in_valid),
        .push_data (rx_in_pkt),
        .pop       (is_rel),
        .empty     (rx_empty),
        .head      (rx_pkt)
    );

    assign txq_valid    = !txq_empty;
    assign alloc_result = s_q.result;
    assign irq_alloc    = s_q.irq_a;
    assign irq_tx       = s_q.irq_t;
endmodule

// File: rtl/pbuf_alloc_chk.sv
module pbuf_alloc_chk #(
    parameter int SLOTS = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic [1:0] irq_ack,
    input logic       tx_done_valid,
    input logic       rx_in_valid,
    input logic [7:0] alloc_result,
    input logic       irq_alloc,
    input logic       irq_tx,
    input logic       txq_valid,
    input logic       txd_empty,
    input logic       rx_empty
);
    // R11
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd2) |=>
        (!txq_valid && txd_empty && rx_empty && !irq_alloc && !irq_tx && alloc_result == 8'h80));

    // R5
    tx_ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack[1] && !tx_done_valid) |=> !irq_tx);

    // R8
    tx_done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done_valid && !(cmd_valid && cmd_op == 3'd2)) |=> irq_tx);

    // R10
    rel_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && !rx_in_valid) |=> rx_empty);

    // R2
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(alloc_result) |-> (irq_alloc || $past(cmd_valid && cmd_op == 3'd2)));

    // R4
    result_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_result[7] ? (alloc_result[6:0] == 7'd0) : (int'(alloc_result[6:0]) < SLOTS));
endmodule

bind pbuf_alloc pbuf_alloc_chk #(.SLOTS(SLOTS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_op        (cmd_op),
    .irq_ack       (irq_ack),
    .tx_done_valid (tx_done_valid),
    .rx_in_valid   (rx_in_valid),
    .alloc_result  (alloc_result),
    .irq_alloc     (irq_alloc),
    .irq_tx        (irq_tx),
    .txq_valid     (txq_valid),
    .txd_empty     (txd_empty),
    .rx_empty      (rx_empty)
);

// File: tb/pbuf_alloc_tb.sv
module pbuf_alloc_tb;
    localparam int PG = 16;
    localparam int SL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [3:0] cmd_count = 4'd0;
    logic [6:0] sel_pkt = 7'd0;
    logic [1:0] irq_ack = 2'd0;
    logic [7:0] alloc_result;
    logic       irq_alloc, irq_tx;
    logic       txq_valid;
    logic [6:0] txq_pkt;
    logic       txq_take = 1'b0;
    logic       tx_done_valid = 1'b0;
    logic [6:0] tx_done_pkt = 7'd0;
    logic       txd_empty;
    logic [6:0] txd_pkt;
    logic       txd_pop = 1'b0;
    logic       rx_in_valid = 1'b0;
    logic [6:0] rx_in_pkt = 7'd0;
    logic       rx_empty;
    logic [6:0] rx_pkt;

    pbuf_alloc #(.PAGES(PG), .SLOTS(SL)) u_dut (.*);

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model
    bit m_pg [PG];
    bit m_used [SL];
    int m_base [SL];
    int m_len [SL];
    int q_tx[$];
    int q_txd[$];
    int q_rx[$];
    bit m_irq_t;

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < PG; i++) m_pg[i] = 0;
        for (int i = 0; i < SL; i++) m_used[i] = 0;
        q_tx.delete();
        q_txd.delete();
        q_rx.delete();
        m_irq_t = 0;
    endfunction

    function automatic int model_alloc(input int n);
        int s;
        int b;
        bit ok;
        s = -1;
        b = -1;
        if (n < 1 || n > 7) return 128;
        for (int i = 0; i < SL; i++) if (!m_used[i] && s < 0) s = i;
        if (s < 0) return 128;
        for (int p = 0; p + n <= PG; p++) begin
            ok = 1;
            for (int j = 0; j < n; j++) if (m_pg[p + j]) ok = 0;
            if (ok && b < 0) b = p;
        end
        if (b < 0) return 128;
        for (int j = 0; j < n; j++) m_pg[b + j] = 1;
        m_used[s] = 1;
        m_base[s] = b;
        m_len[s] = n;
        return s;
    endfunction

    function automatic void model_free(input int p);
        if (p < SL && m_used[p]) begin
            for (int j = 0; j < m_len[p]; j++) m_pg[m_base[p] + j] = 0;
            m_used[p] = 0;
        end
    endfunction

    task automatic check_queues(input string req);
        check(req, "txq_valid", int'(txq_valid), (q_tx.size() > 0) ? 1 : 0);
        if (q_tx.size() > 0) check(req, "txq_pkt", int'(txq_pkt), q_tx[0]);
        check(req, "txd_empty", int'(txd_empty), (q_txd.size() == 0) ? 1 : 0);
        if (q_txd.size() > 0) check(req, "txd_pkt", int'(txd_pkt), q_txd[0]);
        check(req, "rx_empty", int'(rx_empty), (q_rx.size() == 0) ? 1 : 0);
        if (q_rx.size() > 0) check(req, "rx_pkt", int'(rx_pkt), q_rx[0]);
        check(req, "irq_tx", int'(irq_tx), int'(m_irq_t));
    endtask

    task automatic issue(input logic [2:0] op, input logic [3:0] cnt, input logic [6:0] sel);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = op;
        cmd_count = cnt;
        sel_pkt = sel;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = 3'd0;
    endtask

    task automatic ack(input logic [1:0] v);
        @(negedge clk);
        irq_ack = v;
        @(negedge clk);
        irq_ack = 2'd0;
        if (v[1]) m_irq_t = 0;
    endtask

    task automatic wait_alloc();
        int k;
        k = 0;
        while (!irq_alloc && k < 60) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic do_alloc(input int n, input string req);
        int exp;
        if (irq_alloc) ack(2'b01);
        issue(3'd1, 4'(n), 7'd0);
        wait_alloc();
        exp = model_alloc(n);
        check(req, "alloc_result", int'(alloc_result), exp);
        check(req, "irq_alloc", int'(irq_alloc), 1);
        ack(2'b01);
    endtask

    task automatic do_free(input int p, input string req);
        issue(3'd4, 4'd0, 7'(p));
        model_free(p);
        check_queues(req);
    endtask

    task automatic do_enq(input int p, input string req);
        issue(3'd3, 4'd0, 7'(p));
        if (p < SL && m_used[p] && q_tx.size() < SL) q_tx.push_back(p);
        check_queues(req);
    endtask

    task automatic do_take(input string req);
        @(negedge clk);
        txq_take = 1'b1;
        @(negedge clk);
        txq_take = 1'b0;
        if (q_tx.size() > 0) void'(q_tx.pop_front());
        check_queues(req);
    endtask

    task automatic do_txdone(input int p, input string req);
        @(negedge clk);
        tx_done_valid = 1'b1;
        tx_done_pkt = 7'(p);
        @(negedge clk);
        tx_done_valid = 1'b0;
        if (q_txd.size() < SL) q_txd.push_back(p);
        m_irq_t = 1;
        check_queues(req);
    endtask

    task automatic do_txdpop(input string req);
        @(negedge clk);
        txd_pop = 1'b1;
        @(negedge clk);
        txd_pop = 1'b0;
        if (q_txd.size() > 0) void'(q_txd.pop_front());
        check_queues(req);
    endtask

    task automatic do_rxpush(input int p, input string req);
        @(negedge clk);
        rx_in_valid = 1'b1;
        rx_in_pkt = 7'(p);
        @(negedge clk);
        rx_in_valid = 1'b0;
        if (q_rx.size() < SL) q_rx.push_back(p);
        check_queues(req);
    endtask

    task automatic do_release(input string req);
        int h;
        issue(3'd5, 4'd0, 7'd0);
        if (q_rx.size() > 0) begin
            h = q_rx.pop_front();
            model_free(h);
        end
        check_queues(req);
    endtask

    task automatic do_reset_cmd(input string req);
        issue(3'd2, 4'd0, 7'd0);
        model_clear();
        check_queues(req);
        check(req, "alloc_result after reset", int'(alloc_result), 128);
        check(req, "irq_alloc after reset", int'(irq_alloc), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=expired expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", "alloc_result", int'(alloc_result), 128);
        check("R1", "irq_alloc", int'(irq_alloc), 0);
        check_queues("R1");

        // R2 / R4 page exhaustion with two 7-page runs
        do_alloc(7, "R2");
        do_alloc(7, "R2");
        do_alloc(3, "R4");
        do_alloc(2, "R4");
        do_alloc(1, "R4");

        // R3 illegal counts
        do_reset_cmd("R11");
        do_alloc(0, "R3");
        do_alloc(8, "R3");
        do_alloc(15, "R3");

        // R4 packet-number exhaustion
        for (int i = 0; i < 5; i++) do_alloc(1, "R4");

        // R4 first-fit over a fragmented pool
        do_reset_cmd("R11");
        for (int i = 0; i < 4; i++) do_alloc(4, "R4");
        do_free(1, "R9");
        do_free(3, "R9");
        do_alloc(5, "R4");
        do_alloc(4, "R4");
        do_alloc(4, "R4");
        do_free(1, "R9");
        do_free(1, "R9");
        do_alloc(3, "R4");
        do_alloc(2, "R4");

        // R5 write-one-to-clear
        do_reset_cmd("R11");
        issue(3'd1, 4'd2, 7'd0);
        wait_alloc();
        void'(model_alloc(2));
        ack(2'b10);
        check("R5", "irq_alloc after other-bit ack", int'(irq_alloc), 1);
        ack(2'b01);
        check("R5", "irq_alloc after ack", int'(irq_alloc), 0);
        do_txdone(2, "R8");
        @(negedge clk);
        tx_done_valid = 1'b1;
        tx_done_pkt = 7'd1;
        irq_ack = 2'b10;
        @(negedge clk);
        tx_done_valid = 1'b0;
        irq_ack = 2'b00;
        q_txd.push_back(1);
        check("R5", "irq_tx set beats ack", int'(irq_tx), 1);
        ack(2'b10);
        check("R5", "irq_tx after ack", int'(irq_tx), 0);
        do_txdpop("R8");
        do_txdpop("R8");
        do_txdpop("R8");

        // R6 second allocate during search is dropped
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op = 3'd1;
        cmd_count = 4'd1;
        @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op = 3'd0;
        wait_alloc();
        check("R6", "first result", int'(alloc_result), model_alloc(1));
        ack(2'b01);
        repeat (20) @(negedge clk);
        check("R6", "no second completion", int'(irq_alloc), 0);
        do_alloc(1, "R6");

        // R7 enqueue and take, R9 free leaves queues
        do_enq(0, "R7");
        do_enq(2, "R7");
        do_enq(3, "R7");
        do_enq(100, "R7");
        do_free(2, "R9");
        do_take("R7");
        do_take("R7");
        do_take("R7");
        do_take("R7");

        // R10 receive queue
        do_release("R10");
        do_rxpush(0, "R10");
        do_rxpush(1, "R10");
        do_release("R10");
        do_alloc(5, "R10");
        do_release("R10");
        do_release("R10");

        // R12 overfill each queue, then R11 clear with entries present
        for (int i = 0; i < 6; i++) do_rxpush(i, "R12");
        for (int i = 0; i < 6; i++) do_txdone(i + 10, "R12");
        do_alloc(1, "R12");
        for (int i = 0; i < 6; i++) do_enq(0, "R12");
        do_reset_cmd("R11");

        // random traffic against the model
        for (int it = 0; it < 400; it++) begin
            int sel;
            sel = $urandom_range(0, 9);
            case (sel)
                0, 1: do_alloc($urandom_range(0, 9), "R2");
                2: do_free($urandom_range(0, SL + 1), "R9");
                3: do_enq($urandom_range(0, SL), "R7");
                4: begin
                    if ($urandom_range(0, 1) == 1) do_take("R7");
                    else do_txdpop("R8");
                end
                5: do_txdone($urandom_range(0, 127), "R8");
                6: do_rxpush($urandom_range(0, SL), "R10");
                7: do_release("R10");
                8: begin
                    ack(2'b10);
                    check_queues("R5");
                end
                default: begin
                    if ($urandom_range(0, 15) == 0) do_reset_cmd("R11");
                    else check_queues("R12");
                end
            endcase
        end

        finish_run();
    end
endmodule